// File: doc/BRIEF.md
# MESI Coherence Controller with Shared-Line Snoop Response

This block keeps the coherence state of every line in one private writeback cache that sits on an atomic snooping bus with its peers. Each line is held in one of four states: Modified, Exclusive, Shared or Invalid. Processor requests that need the bus are turned into bus reads, read-for-ownership requests or writebacks. Transactions that other agents put on the bus arrive on the snoop port, and the block answers them by driving a wired-OR shared line and a flush (data supply) strobe. Data movement, memory, the bus arbiter and the tag/data arrays live outside the block.

A read miss cannot know its fill state until its bus read has been granted and the peers have answered on the shared line, so the request passes through a one-cycle transient wait state. Only then is the line written as Exclusive (nobody else holds it) or Shared. Writing an Exclusive line upgrades it to Modified silently. When several caches hold a clean copy, exactly one of them supplies the data: the holder with the lowest cache ID. Each cache learns who else holds the line from a holder vector that comes with the snoop.

Back-pressure rules: the processor port is valid/ready. A request is taken on a cycle where `cpu_valid` and `cpu_ready` are both high. `cpu_ready` is low while a request is outstanding and while `snp_valid` is high. The bus request port is also valid/ready. Once `bus_valid` rises, it stays high with `bus_cmd` and `bus_line` unchanged until a cycle with `bus_ready` high. The system never presents a snoop in the same cycle as this cache's own grant or transient wait.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, `cpu_ready` is high, and `bus_valid` and `cpu_resp_valid` are low.
- R2: A read (op 0) of an Invalid line issues a bus read (cmd 0). `shared_in` is sampled in the cycle after the grant. One cycle later the response reports Exclusive (state code 2) if `shared_in` was low, or Shared (code 1) if it was high. No response appears in the transient cycle.
- R3: A read of a Shared, Exclusive or Modified line (M code 3) issues no bus request and responds one cycle after acceptance with the unchanged state.
- R4: A write (op 1) to an Exclusive or Modified line issues no bus request and leaves the line Modified, with the response one cycle after acceptance.
- R5: A write to a Shared or Invalid line issues a read-for-ownership (cmd 1). The line becomes Modified, and this is reported one cycle after the grant.
- R6: An evict (op 2) of a Modified line issues a writeback (cmd 2) and leaves the line Invalid. An evict in any other state is silent and leaves the line Invalid.
- R7: A snooped bus read (snoop cmd 0) of a Modified or Exclusive line asserts `snp_flush` and `snp_shared` and moves the line to Shared.
- R8: A snooped read-for-ownership (snoop cmd 1) of a Modified or Exclusive line asserts `snp_flush` and moves the line to Invalid.
- R9: For a Shared line, `snp_flush` is asserted only if no peer with a lower ID is marked in `snp_holders`. A snooped bus read keeps the line Shared and asserts `snp_shared`. A snooped read-for-ownership invalidates the line.
- R10: A snoop of an Invalid line asserts neither `snp_flush` nor `snp_shared` and leaves the line Invalid.
- R11: `cpu_ready` is low while a request is outstanding or `snp_valid` is high. A pending bus request holds `bus_valid`, `bus_cmd` and `bus_line` stable until it is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request valid |
| cpu_ready | output | 1 | Processor request accepted when high with valid |
| cpu_op | input | 2 | 0 read, 1 write, 2 evict, 3 treated as read |
| cpu_line | input | LW | Line index of the request |
| cpu_resp_valid | output | 1 | One-cycle pulse when a request completes |
| cpu_resp_state | output | 2 | Line state after the request (0 I, 1 S, 2 E, 3 M) |
| bus_valid | output | 1 | Bus request pending |
| bus_ready | input | 1 | Bus grant for the pending request |
| bus_cmd | output | 2 | 0 read, 1 read-for-ownership, 2 writeback |
| bus_line | output | LW | Line index of the bus request |
| shared_in | input | 1 | Wired-OR shared result, sampled in the cycle after a read grant |
| snp_valid | input | 1 | Snooped transaction from another agent |
| snp_cmd | input | 2 | Snooped command, same coding as bus_cmd |
| snp_line | input | LW | Line index of the snooped transaction |
| snp_holders | input | NCACHE | Peers holding a valid copy, one bit per cache ID |
| snp_flush | output | 1 | This cache supplies the line's data |
| snp_shared | output | 1 | This cache drives the shared line |

## Verification
The hardest situation to reach from the ports is a Shared line being snooped when the holder vector names a lower-ID peer. For that, the line must first be filled with `shared_in` high in the single transient cycle, and then a snoop must arrive with varied holder bits. The bench drives `shared_in` exactly in the cycle after each read grant, with random grant delays. It then mixes random snoops whose holder vectors randomly include or omit the lower-ID caches. Directed sequences also walk one line through every state transition, and each result is read back with read hits.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} line_st_t;
  typedef enum logic [1:0] {BC_RD = 2'd0, BC_RDX = 2'd1, BC_WB = 2'd2, BC_NONE = 2'd3} bus_cmd_t;
  typedef enum logic [1:0] {OP_RD = 2'd0, OP_WR = 2'd1, OP_EV = 2'd2, OP_TOUCH = 2'd3} cpu_op_t;
  typedef enum logic [1:0] {F_IDLE = 2'd0, F_REQ = 2'd1, F_WAIT = 2'd2} req_fsm_t;
endpackage

// File: rtl/mesi_state_array.sv
module mesi_state_array
  import mesi_pkg::*;
#(
  parameter int LINES = 8,
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] ra_idx,
  output line_st_t      ra_st,
  input  logic [LW-1:0] rb_idx,
  output line_st_t      rb_st,
  input  logic          wa_en,
  input  logic [LW-1:0] wa_idx,
  input  line_st_t      wa_st,
  input  logic          wb_en,
  input  logic [LW-1:0] wb_idx,
  input  line_st_t      wb_st
);
  logic [2*LINES-1:0] flat;

  for (genvar g = 0; g < LINES; g++) begin : g_cell
    line_st_t cell_q;
    always_ff @(posedge clk) begin
      if (!rst_n) cell_q <= ST_I;
      else if (wb_en && wb_idx == LW'(g)) cell_q <= wb_st;
      else if (wa_en && wa_idx == LW'(g)) cell_q <= wa_st;
    end
    assign flat[2*g +: 2] = cell_q;
  end

  assign ra_st = line_st_t'(flat[{ra_idx, 1'b0} +: 2]);
  assign rb_st = line_st_t'(flat[{rb_idx, 1'b0} +: 2]);
endmodule

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp
  import mesi_pkg::*;
#(
  parameter int NCACHE = 4,
  parameter int CACHE_ID = 0
) (
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [NCACHE-1:0] holders,
  input  line_st_t          cur_st,
  output logic              flush,
  output logic              shared_o,
  output logic              upd,
  output line_st_t          nxt_st
);
  logic lower_holds;
  logic is_rd, is_rdx;

  always_comb begin
    lower_holds = 1'b0;
    for (int i = 0; i < CACHE_ID; i++) lower_holds = lower_holds | holders[i];
  end

  always_comb begin
    is_rd    = snp_valid && bus_cmd_t'(snp_cmd) == BC_RD;
    is_rdx   = snp_valid && bus_cmd_t'(snp_cmd) == BC_RDX;
    flush    = 1'b0;
    shared_o = 1'b0;
    upd      = 1'b0;
    nxt_st   = cur_st;
    if ((is_rd || is_rdx) && cur_st != ST_I) begin
      upd      = 1'b1;
      nxt_st   = is_rd ? ST_S : ST_I;
      shared_o = is_rd;
      // owners always supply; among clean sharers only the lowest ID does
      flush    = (cur_st == ST_S) ? !lower_holds : 1'b1;
    end
  end
endmodule

// File: rtl/mesi_req_fsm.sv
module mesi_req_fsm
  import mesi_pkg::*;
#(
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_valid,
  output logic          cpu_ready,
  input  logic [1:0]    cpu_op,
  input  logic [LW-1:0] cpu_line,
  input  logic          snoop_busy,
  output logic [LW-1:0] look_line,
  input  line_st_t      cur_st,
  output logic          bus_valid,
  input  logic          bus_ready,
  output logic [1:0]    bus_cmd,
  output logic [LW-1:0] bus_line,
  input  logic          shared_in,
  output logic          we,
  output logic [LW-1:0] widx,
  output line_st_t      wst,
  output logic          resp_valid,
  output line_st_t      resp_state
);
  req_fsm_t      st_q, st_d;
  bus_cmd_t      pend_q, pend_d;
  logic [LW-1:0] line_q, line_d;
  logic          done;
  line_st_t      done_st;

  always_comb begin
    cpu_ready = (st_q == F_IDLE) && !snoop_busy;
    look_line = (st_q == F_IDLE) ? cpu_line : line_q;
    bus_valid = (st_q == F_REQ);
    bus_cmd   = pend_q;
    bus_line  = line_q;
    st_d = st_q; pend_d = pend_q; line_d = line_q;
    we = 1'b0; widx = look_line; wst = ST_I;
    done = 1'b0; done_st = ST_I;
    unique case (st_q)
      F_IDLE: if (cpu_valid && cpu_ready) begin
        line_d = cpu_line;
        unique case (cpu_op_t'(cpu_op))
          OP_WR: if (cur_st == ST_E || cur_st == ST_M) begin
            we = 1'b1; wst = ST_M; done = 1'b1; done_st = ST_M;
          end else begin
            pend_d = BC_RDX; st_d = F_REQ;
          end
          OP_EV: if (cur_st == ST_M) begin
            pend_d = BC_WB; st_d = F_REQ;
          end else begin
            we = 1'b1; wst = ST_I; done = 1'b1; done_st = ST_I;
          end
          default: if (cur_st == ST_I) begin
            pend_d = BC_RD; st_d = F_REQ;
          end else begin
            done = 1'b1; done_st = cur_st;
          end
        endcase
      end
      F_REQ: if (bus_ready) begin
        if (pend_q == BC_RD) st_d = F_WAIT;
        else begin
          we = 1'b1; wst = (pend_q == BC_RDX) ? ST_M : ST_I;
          done = 1'b1; done_st = wst; st_d = F_IDLE;
        end
      end
      F_WAIT: begin
        // transient: fill state decided by the peers' answer
        we = 1'b1; wst = shared_in ? ST_S : ST_E;
        done = 1'b1; done_st = wst; st_d = F_IDLE;
      end
      default: st_d = F_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= F_IDLE; pend_q <= BC_RD; line_q <= '0;
      resp_valid <= 1'b0; resp_state <= ST_I;
    end else begin
      st_q <= st_d; pend_q <= pend_d; line_q <= line_d;
      resp_valid <= done; resp_state <= done_st;
    end
  end

  a_r11_bus_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_cmd) && $stable(bus_line));
  a_r2_fill_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_ready && bus_cmd == BC_RD |=> !resp_valid ##1
      resp_valid && resp_state == ($past(shared_in) ? ST_S : ST_E));
  a_r5_rdx_gives_m: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_ready && bus_cmd == BC_RDX |=> resp_valid && resp_state == ST_M);
  a_r6_wb_gives_i: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_ready && bus_cmd == BC_WB |=> resp_valid && resp_state == ST_I);
endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
  import mesi_pkg::*;
#(
  parameter int LINES = 8,
  parameter int NCACHE = 4,
  parameter int CACHE_ID = 0,
  localparam int LW = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  output logic              cpu_ready,
  input  logic [1:0]        cpu_op,
  input  logic [LW-1:0]     cpu_line,
  output logic              cpu_resp_valid,
  output logic [1:0]        cpu_resp_state,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic [1:0]        bus_cmd,
  output logic [LW-1:0]     bus_line,
  input  logic              shared_in,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [LW-1:0]     snp_line,
  input  logic [NCACHE-1:0] snp_holders,
  output logic              snp_flush,
  output logic              snp_shared
);
  logic [LW-1:0] look_line, widx;
  line_st_t      cpu_st, snp_st, wst, snp_nxt, resp_st;
  logic          we, snp_upd;

  mesi_state_array #(.LINES(LINES), .LW(LW)) u_arr (
    .clk(clk), .rst_n(rst_n),
    .ra_idx(look_line), .ra_st(cpu_st),
    .rb_idx(snp_line), .rb_st(snp_st),
    .wa_en(we), .wa_idx(widx), .wa_st(wst),
    .wb_en(snp_upd), .wb_idx(snp_line), .wb_st(snp_nxt)
  );

  mesi_snoop_resp #(.NCACHE(NCACHE), .CACHE_ID(CACHE_ID)) u_snp (
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .holders(snp_holders),
    .cur_st(snp_st), .flush(snp_flush), .shared_o(snp_shared),
    .upd(snp_upd), .nxt_st(snp_nxt)
  );

  mesi_req_fsm #(.LW(LW)) u_req (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_op(cpu_op), .cpu_line(cpu_line),
    .snoop_busy(snp_valid), .look_line(look_line), .cur_st(cpu_st),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_cmd(bus_cmd), .bus_line(bus_line),
    .shared_in(shared_in), .we(we), .widx(widx), .wst(wst),
    .resp_valid(cpu_resp_valid), .resp_state(resp_st)
  );
  assign cpu_resp_state = resp_st;

  a_r7_owner_supplies: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && snp_cmd == BC_RD && (snp_st == ST_M || snp_st == ST_E)
      |-> snp_flush && snp_shared);
  a_r10_invalid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && snp_st == ST_I |-> !snp_flush && !snp_shared);
  a_r11_snoop_blocks_cpu: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> !cpu_ready);
endmodule

// File: tb/mesi_snoop_ctrl_tb_top.sv
module mesi_snoop_ctrl_tb_top;
  localparam int CLK_P = 10;
  localparam int LINES = 8;
  localparam int NC = 4;
  localparam int MYID = 2;
  localparam int LW = 3;

  logic clk = 0, rst_n = 0;
  logic cpu_valid = 0, bus_ready = 0, shared_in = 0, snp_valid = 0;
  logic [1:0] cpu_op = 0, snp_cmd = 0;
  logic [LW-1:0] cpu_line = 0, snp_line = 0;
  logic [NC-1:0] snp_holders = 0;
  logic cpu_ready, cpu_resp_valid, bus_valid, snp_flush, snp_shared;
  logic [1:0] cpu_resp_state, bus_cmd;
  logic [LW-1:0] bus_line;

  int vectors = 0, fails = 0;
  logic [1:0] mdl [LINES];

  always #(CLK_P/2) clk = ~clk;

  mesi_snoop_ctrl #(.LINES(LINES), .NCACHE(NC), .CACHE_ID(MYID)) dut_i (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // expected outcome of a processor op from the model
  function automatic void plan_op(input int op, input logic [1:0] cur, input bit sh,
                                  output bit nb, output int cmd, output logic [1:0] fin,
                                  output string tag);
    nb = 0; cmd = 0; fin = cur; tag = "R3";
    if (op == 1) begin
      fin = 2'd3;
      if (cur == 2'd2 || cur == 2'd3) tag = "R4";
      else begin nb = 1; cmd = 1; tag = "R5"; end
    end else if (op == 2) begin
      fin = 2'd0; tag = "R6";
      if (cur == 2'd3) begin nb = 1; cmd = 2; end
    end else if (cur == 2'd0) begin
      nb = 1; cmd = 0; fin = sh ? 2'd1 : 2'd2; tag = "R2";
    end
  endfunction

  task automatic do_cpu(input int op, input int ln, input bit sh);
    bit nb; int cmd; logic [1:0] fin; string tag;
    plan_op(op, mdl[ln], sh, nb, cmd, fin, tag);
    @(negedge clk);
    chk(cpu_ready == 1'b1, "R11", int'(cpu_ready), 1);
    cpu_valid = 1; cpu_op = 2'(op); cpu_line = LW'(ln);
    @(negedge clk);
    cpu_valid = 0;
    if (!nb) begin
      chk(bus_valid == 1'b0, tag, int'(bus_valid), 0);
    end else begin
      chk(bus_valid && bus_cmd == 2'(cmd) && bus_line == LW'(ln), tag, int'(bus_cmd), cmd);
      for (int d = int'($urandom % 3); d > 0; d--) begin
        @(negedge clk);
        chk(bus_valid && bus_cmd == 2'(cmd) && !cpu_ready, "R11", int'(bus_valid), 1);
      end
      bus_ready = 1;
      @(negedge clk);
      bus_ready = 0;
      if (cmd == 0) begin
        chk(cpu_resp_valid == 1'b0, "R2", int'(cpu_resp_valid), 0);
        shared_in = sh;
        @(negedge clk);
        shared_in = 0;
      end
    end
    chk(cpu_resp_valid && cpu_resp_state == fin, tag, int'(cpu_resp_state), int'(fin));
    mdl[ln] = fin;
  endtask

  task automatic do_snp(input int cmd, input int ln, input logic [NC-1:0] hold);
    logic [1:0] cur; bit vld, sup, ef, es; string tag;
    cur = mdl[ln]; vld = (cur != 2'd0);
    sup = vld && ((hold & NC'((1 << MYID) - 1)) == '0);
    ef  = (cur == 2'd1) ? sup : vld;
    es  = (cmd == 0) && vld;
    if (cur == 2'd0) tag = "R10";
    else if (cur == 2'd1) tag = "R9";
    else tag = (cmd == 0) ? "R7" : "R8";
    @(negedge clk);
    snp_valid = 1; snp_cmd = 2'(cmd); snp_line = LW'(ln); snp_holders = hold;
    #(CLK_P/4);
    chk(snp_flush == ef, tag, int'(snp_flush), int'(ef));
    chk(snp_shared == es, tag, int'(snp_shared), int'(es));
    chk(cpu_ready == 1'b0, "R11", int'(cpu_ready), 0);
    @(negedge clk);
    snp_valid = 0;
    if (vld) mdl[ln] = (cmd == 0) ? 2'd1 : 2'd0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < LINES; i++) mdl[i] = 2'd0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: idle outputs after reset
    chk(cpu_ready && !bus_valid && !cpu_resp_valid, "R1", int'(cpu_ready), 1);
    // R1: every line Invalid, seen as quiet snoops
    for (int i = 0; i < LINES; i++) do_snp(0, i, '0);

    // directed walk on line 0
    do_cpu(0, 0, 0);          // R2 miss -> E
    do_cpu(1, 0, 0);          // R4 silent upgrade -> M
    do_cpu(1, 0, 0);          // R4 write hit in M
    do_snp(0, 0, 4'b0001);    // R7 owner flushes even with lower holder -> S
    do_cpu(0, 0, 0);          // R3 hit in S
    do_snp(0, 0, 4'b0010);    // R9 lower holder present: no flush
    do_snp(0, 0, 4'b1000);    // R9 only higher holder: flush
    do_cpu(1, 0, 0);          // R5 write in S -> RDX -> M
    do_cpu(2, 0, 0);          // R6 evict M -> writeback
    do_cpu(2, 0, 0);          // R6 evict I silent
    do_cpu(1, 0, 0);          // R5 write in I -> M
    do_snp(1, 0, 4'b0000);    // R8 RDX on M -> I
    do_cpu(0, 1, 1);          // R2 miss with shared -> S
    do_snp(1, 1, 4'b0001);    // R9 RDX on S, not supplier -> I
    do_cpu(0, 1, 1);          // R2 -> S
    do_cpu(2, 1, 0);          // R6 evict S silent
    do_cpu(0, 2, 0);          // R2 -> E
    do_snp(1, 2, 4'b0011);    // R8 RDX on E -> flush, I
    do_cpu(0, 2, 0);          // R2 -> E
    do_cpu(2, 2, 0);          // R6 evict E silent

    for (int k = 0; k < 600; k++) begin
      if ($urandom % 10 < 7) do_cpu(int'($urandom % 3), int'($urandom % LINES), 1'($urandom % 2));
      else do_snp(int'($urandom % 2), int'($urandom % LINES), NC'($urandom));
    end
    // read back every line's final state through read ops
    for (int i = 0; i < LINES; i++) do_cpu(0, i, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule